// File: doc/BRIEF.md
# Dual Data Pointer Register File

This block keeps two 16-bit data pointers for an 8051-style core together with a one-bit selector that names the active pointer. Software reaches all of it through the core's special-function-register port: each pointer appears as a low and a high byte at fixed addresses, and the selector lives in bit 0 of a fifth register. Byte writes take effect on the next clock. Reads are combinational from the address.

On the core side, the block drives the active pointer out as the external data address. It accepts three commands, which always act on the pointer that is currently selected: load a 16-bit value, increment by one, and flip the selector. Flipping the selector lets block-move code switch from a source address to a destination address with a single operation, without saving either address.

Top module: `dptr_bank`

## Requirements
- R1: After reset both pointers, the selector, `addr_o`, `sel_o` and the read data of every pointer and selector address are all zero.
- R2: SFR address 82h holds pointer 0 bits 7:0, 83h holds pointer 0 bits 15:8, 84h holds pointer 1 bits 7:0 and 85h holds pointer 1 bits 15:8. A write updates only the addressed byte from the next cycle, and a read returns the byte combinationally.
- R3: SFR address 86h holds the selector in bit 0 (0 = pointer 0, 1 = pointer 1). A write stores only `sfr_wdata_i[0]`. Bits 7:1 are ignored on write and always read 0. Reads of any other address return 0.
- R4: `ld_i` loads `ld_val_i` into the selected pointer at the next clock.
- R5: `inc_i` adds one to the selected pointer at the next clock, carrying from the low byte into the high byte and wrapping FFFFh to 0000h.
- R6: When `ld_i` and `inc_i` are both high, the load wins and no increment is applied.
- R7: `sel_flip_i` inverts the selector at the next clock. An SFR write to 86h in the same cycle wins over the flip.
- R8: An SFR write to either byte of the selected pointer in the same cycle as `ld_i` or `inc_i` takes priority. The addressed byte takes the written value, the other byte keeps its old value, and the core command is dropped.
- R9: `addr_o` always equals the selected pointer and `sel_o` equals the selector. A core command issued in the same cycle as a selector change acts on the previously selected pointer, and `addr_o` shows the newly selected pointer from the next cycle.
- R10: Core commands never change the unselected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data for `sfr_addr_i` |
| ld_i | input | 1 | Load the selected pointer |
| ld_val_i | input | 16 | Value for the load |
| inc_i | input | 1 | Increment the selected pointer |
| sel_flip_i | input | 1 | Invert the selector |
| addr_o | output | 16 | Selected pointer, used as the data address |
| sel_o | output | 1 | Current selector |

## Verification
The interesting collisions are an SFR write and a core command that land in the same cycle. One case is a byte write to the selected pointer together with an increment or a load. The other is a write to 86h together with a selector flip. Each pair is driven in a single cycle from a known pointer value. The winner is then judged on the data address and on byte read-backs taken in the following cycle. A flip combined with an increment is also driven, to show that the command lands on the old pointer while the address follows the new one.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  localparam int unsigned SFR_AW  = 8;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_PTR = 2;
  localparam int unsigned PTR_W   = 2 * BYTE_W;
  localparam logic [SFR_AW-1:0] PTR_BASE = 8'h82;
  localparam logic [SFR_AW-1:0] SEL_ADDR = PTR_BASE + SFR_AW'(2 * NUM_PTR);

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_P0_LO,
    SRC_P0_HI,
    SRC_P1_LO,
    SRC_P1_HI,
    SRC_SEL
  } rd_src_e;
endpackage

// File: rtl/dptr_decode.sv
module dptr_decode
  import dptr_pkg::*;
(
  input  logic              we_i,
  input  logic [SFR_AW-1:0] addr_i,
  output logic [NUM_PTR-1:0] wr_lo_o,
  output logic [NUM_PTR-1:0] wr_hi_o,
  output logic              wr_sel_o,
  output rd_src_e           rd_src_o
);
  for (genvar g = 0; g < NUM_PTR; g++) begin : g_dec
    localparam logic [SFR_AW-1:0] LoAddr = PTR_BASE + SFR_AW'(2 * g);
    localparam logic [SFR_AW-1:0] HiAddr = PTR_BASE + SFR_AW'(2 * g + 1);
    assign wr_lo_o[g] = we_i && (addr_i == LoAddr);
    assign wr_hi_o[g] = we_i && (addr_i == HiAddr);
  end

  assign wr_sel_o = we_i && (addr_i == SEL_ADDR);

  always_comb begin
    unique case (addr_i)
      PTR_BASE:             rd_src_o = SRC_P0_LO;
      PTR_BASE + 8'd1:      rd_src_o = SRC_P0_HI;
      PTR_BASE + 8'd2:      rd_src_o = SRC_P1_LO;
      PTR_BASE + 8'd3:      rd_src_o = SRC_P1_HI;
      SEL_ADDR:             rd_src_o = SRC_SEL;
      default:              rd_src_o = SRC_NONE;
    endcase
  end
endmodule

// File: rtl/dptr_reg.sv
module dptr_reg
  import dptr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             ld_i,
  input  logic [PTR_W-1:0] ld_val_i,
  input  logic             inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [PTR_W-1:0] q_o
);
  localparam logic [PTR_W-1:0] One = PTR_W'(1);

  logic [PTR_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_lo_i || wr_hi_i) begin
      // software byte write beats any core command
      if (wr_lo_i) q_d[BYTE_W-1:0]     = wdata_i;
      if (wr_hi_i) q_d[PTR_W-1:BYTE_W] = wdata_i;
    end else if (act_i && ld_i) begin
      q_d = ld_val_i;
    end else if (act_i && inc_i) begin
      q_d = q_o + One;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/dptr_sel.sv
module dptr_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic flip_i,
  output logic sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= 1'b0;
    else if (wr_i)   sel_o <= wbit_i;
    else if (flip_i) sel_o <= ~sel_o;
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank
  import dptr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sfr_we_i,
  input  logic [7:0]  sfr_addr_i,
  input  logic [7:0]  sfr_wdata_i,
  output logic [7:0]  sfr_rdata_o,
  input  logic        ld_i,
  input  logic [15:0] ld_val_i,
  input  logic        inc_i,
  input  logic        sel_flip_i,
  output logic [15:0] addr_o,
  output logic        sel_o
);
  logic [NUM_PTR-1:0] wr_lo, wr_hi;
  logic               wr_sel;
  rd_src_e            rd_src;
  logic [PTR_W-1:0]   ptr_q [NUM_PTR];

  dptr_decode u_dec (
    .we_i    (sfr_we_i),
    .addr_i  (sfr_addr_i),
    .wr_lo_o (wr_lo),
    .wr_hi_o (wr_hi),
    .wr_sel_o(wr_sel),
    .rd_src_o(rd_src)
  );

  dptr_sel u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_sel),
    .wbit_i(sfr_wdata_i[0]),
    .flip_i(sel_flip_i),
    .sel_o (sel_o)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    dptr_reg u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (sel_o == 1'(g)),
      .ld_i    (ld_i),
      .ld_val_i(ld_val_i),
      .inc_i   (inc_i),
      .wr_lo_i (wr_lo[g]),
      .wr_hi_i (wr_hi[g]),
      .wdata_i (sfr_wdata_i),
      .q_o     (ptr_q[g])
    );
  end

  assign addr_o = ptr_q[sel_o];

  always_comb begin
    unique case (rd_src)
      SRC_P0_LO: sfr_rdata_o = ptr_q[0][BYTE_W-1:0];
      SRC_P0_HI: sfr_rdata_o = ptr_q[0][PTR_W-1:BYTE_W];
      SRC_P1_LO: sfr_rdata_o = ptr_q[1][BYTE_W-1:0];
      SRC_P1_HI: sfr_rdata_o = ptr_q[1][PTR_W-1:BYTE_W];
      SRC_SEL:   sfr_rdata_o = {7'd0, sel_o};
      default:   sfr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dptr_bank_chk.sv
module dptr_bank_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sfr_we_i,
  input logic [7:0]  sfr_addr_i,
  input logic [7:0]  sfr_wdata_i,
  input logic [7:0]  sfr_rdata_o,
  input logic        ld_i,
  input logic [15:0] ld_val_i,
  input logic        inc_i,
  input logic        sel_flip_i,
  input logic [15:0] addr_o,
  input logic        sel_o
);
  // R4
  load_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !sfr_we_i && !sel_flip_i) |=> addr_o == $past(ld_val_i));

  // R5
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !sfr_we_i && !sel_flip_i) |=> addr_o == $past(addr_o) + 16'd1);

  // R7
  flip_toggles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_flip_i && !sfr_we_i) |=> sel_o != $past(sel_o));

  // R3
  sel_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_we_i && sfr_addr_i == 8'h86) |=> sel_o == $past(sfr_wdata_i[0]));

  // R3
  sel_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_addr_i == 8'h86) |-> sfr_rdata_o == {7'd0, sel_o});

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !inc_i && !sfr_we_i && !sel_flip_i) |=> $stable(addr_o) && $stable(sel_o));
endmodule

bind dptr_bank dptr_bank_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sfr_we_i   (sfr_we_i),
  .sfr_addr_i (sfr_addr_i),
  .sfr_wdata_i(sfr_wdata_i),
  .sfr_rdata_o(sfr_rdata_o),
  .ld_i       (ld_i),
  .ld_val_i   (ld_val_i),
  .inc_i      (inc_i),
  .sel_flip_i (sel_flip_i),
  .addr_o     (addr_o),
  .sel_o      (sel_o)
);

// File: tb/tb_dptr_bank.sv
module tb_dptr_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic [7:0]  sfr_rdata;
  logic        ld = 1'b0;
  logic [15:0] ld_val = 16'h0;
  logic        inc = 1'b0;
  logic        flip = 1'b0;
  logic [15:0] addr;
  logic        sel;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  dptr_bank dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
    .sfr_rdata_o(sfr_rdata),
    .ld_i(ld), .ld_val_i(ld_val), .inc_i(inc), .sel_flip_i(flip),
    .addr_o(addr), .sel_o(sel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock with the given stimulus; inputs released after the edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic l, input logic [15:0] lv, input logic i, input logic f);
    @(negedge clk);
    sfr_we = we; sfr_addr = a; sfr_wdata = d; ld = l; ld_val = lv; inc = i; flip = f;
    @(posedge clk);
    #1;
    sfr_we = 1'b0; ld = 1'b0; inc = 1'b0; flip = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    sfr_addr = a;
    #1;
    v = sfr_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 addr", addr, 16'h0);
    chk("R1 sel", {15'd0, sel}, 16'h0);
    for (int a = 8'h82; a <= 8'h86; a++) begin
      rd(8'(a), v);
      chk("R1 read", {8'd0, v}, 16'h0);
    end
  endtask

  task automatic t_sfr_rw();
    logic [7:0] v;
    wr(8'h82, 8'h34); wr(8'h83, 8'h12); wr(8'h84, 8'hCD); wr(8'h85, 8'hAB);
    rd(8'h82, v); chk("R2 p0 lo", {8'd0, v}, 16'h0034);
    rd(8'h83, v); chk("R2 p0 hi", {8'd0, v}, 16'h0012);
    rd(8'h84, v); chk("R2 p1 lo", {8'd0, v}, 16'h00CD);
    rd(8'h85, v); chk("R2 p1 hi", {8'd0, v}, 16'h00AB);
    chk("R9 addr p0", addr, 16'h1234);
    rd(8'h90, v); chk("R3 other addr", {8'd0, v}, 16'h0);
  endtask

  task automatic t_sel_reg();
    logic [7:0] v;
    wr(8'h86, 8'hFE);
    chk("R3 sel bit0 only", {15'd0, sel}, 16'h0);
    rd(8'h86, v); chk("R3 read 86 zero", {8'd0, v}, 16'h0);
    wr(8'h86, 8'hFF);
    chk("R3 sel set", {15'd0, sel}, 16'h1);
    rd(8'h86, v); chk("R3 read 86 one", {8'd0, v}, 16'h1);
    chk("R9 addr p1", addr, 16'hABCD);
  endtask

  task automatic t_load();
    logic [7:0] v;
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 16'h5555, 1'b0, 1'b0);
    chk("R4 load p1", addr, 16'h5555);
    rd(8'h82, v); chk("R10 p0 lo kept", {8'd0, v}, 16'h0034);
    rd(8'h83, v); chk("R10 p0 hi kept", {8'd0, v}, 16'h0012);
  endtask

  task automatic t_inc();
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 16'h00FF, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R5 carry", addr, 16'h0100);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R5 wrap", addr, 16'h0000);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, 16'h2222, 1'b1, 1'b0);
    chk("R6 load wins", addr, 16'h2222);
  endtask

  task automatic t_flip();
    logic [7:0] v;
    // sel=1, p1=2222, p0=1234: flip with inc hits p1
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, 1'b1);
    chk("R7 flip", {15'd0, sel}, 16'h0);
    chk("R9 addr follows new sel", addr, 16'h1234);
    rd(8'h84, v); chk("R9 inc on old ptr", {8'd0, v}, 16'h0023);
    cyc(1'b0, 8'h00, 8'h00, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R7 flip back", {15'd0, sel}, 16'h1);
    cyc(1'b1, 8'h86, 8'h01, 1'b0, 16'h0, 1'b0, 1'b1);
    chk("R7 write beats flip", {15'd0, sel}, 16'h1);
  endtask

  task automatic t_collide();
    wr(8'h86, 8'h00);
    cyc(1'b1, 8'h82, 8'h77, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R8 write beats inc", addr, 16'h1277);
    cyc(1'b1, 8'h83, 8'h99, 1'b1, 16'h4444, 1'b0, 1'b0);
    chk("R8 write beats load", addr, 16'h9977);
    // write to unselected pointer does not block inc on selected one
    cyc(1'b1, 8'h84, 8'h00, 1'b0, 16'h0, 1'b1, 1'b0);
    chk("R10 inc on sel only", addr, 16'h9978);
  endtask

  initial begin
    fork
      begin
        #1;
        t_reset();
        #5 rst_n = 1'b1;
        t_sfr_rw();
        t_sel_reg();
        t_load();
        t_inc();
        t_flip();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule